// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block combines four reset requests into the chip reset and keeps a record of what caused the reset. The four requests are a power-on-clear pulse, a low-voltage-detect request, a watchdog overflow and an external active-low pin. The pin is accepted only after it has stayed low for a minimum number of reference ticks. Ticks that arrive while the supply is flagged invalid are not counted. After every request has gone away, the chip reset is held for a further fixed number of clock cycles.

The reset reaches its consumers as separate outputs. The core reset covers every cause, and the watchdog's own logic is reset by every cause, including a watchdog overflow. The low-voltage detector's logic is spared when the low-voltage detector alone caused the reset. While reset is held, every oscillator enable is forced off. Port drivers are released to high impedance, except for one chosen pin, which drives low. A retain signal tells the memory that its contents are preserved, which holds in every reset episode except one started by power-on-clear.

Software reads a cause register. The read strobe clears the register after the access. Power-on-clear wipes the whole register. All inputs are synchronous to `clk`. The power-on-clear input also serves as the block's own synchronous active-high reset.

Top module: `reset_hub`

## Requirements
- R1: A low external pin asserts the reset once it has been sampled low on 10 reference ticks. Nine ticks do not assert it. The pin going high clears the count.
- R2: A tick that arrives while `supply_ok_i` is low is not counted. The partial count is kept until the supply is valid again.
- R3: Any active request raises `sys_rst_o` on the next clock edge. `sys_rst_o` falls on the 16th edge at which no request is present.
- R4: Cause bit 0 is set by a watchdog overflow and bit 1 by a low-voltage request. An external pin reset sets no bit. Bits 7:2 always read 0.
- R5: A cycle with `cause_rd_i` high clears the cause register on the next edge. A cause arriving in that same cycle is still recorded.
- R6: Power-on-clear clears the whole cause register to 0x00. If the low-voltage request is still high after power-on-clear drops, bit 1 reads 1 after that first reset.
- R7: `lvd_rst_o` stays low during a reset caused only by the low-voltage request. It is high during resets that include power-on-clear, the external pin or the watchdog.
- R8: `wdt_rst_o` is high during every reset, including one caused by the watchdog.
- R9: While `sys_rst_o` is high, `osc_en_o` is all zero. Otherwise it follows `osc_req_i`.
- R10: While `sys_rst_o` is high, `port_oe_o` is zero except bit LOW_PIN (default 5). That bit has output enable 1 and data 0. Otherwise both port outputs follow their inputs.
- R11: `ram_keep_o` is low from a power-on-clear request until that reset releases. It is high at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_i | input | 1 | Power-on-clear request, also the block's own synchronous reset |
| tick_i | input | 1 | One-cycle strobe of the pin-width reference |
| supply_ok_i | input | 1 | Supply is in its valid range |
| ext_rst_n_i | input | 1 | External reset pin, active low, already synchronous |
| lvd_req_i | input | 1 | Low-voltage-detect reset request |
| wdt_ovf_i | input | 1 | Watchdog overflow reset request |
| cause_rd_i | input | 1 | Read strobe for the cause register, clears it |
| osc_req_i | input | N_OSC | Oscillator enables requested by the clock controller |
| port_oe_i | input | N_PORT | Functional port output enables |
| port_do_i | input | N_PORT | Functional port output data |
| cause_o | output | 8 | Cause register contents |
| sys_rst_o | output | 1 | Core domain reset |
| wdt_rst_o | output | 1 | Watchdog domain reset |
| lvd_rst_o | output | 1 | Low-voltage-detector domain reset |
| ram_keep_o | output | 1 | Memory contents are retained |
| osc_en_o | output | N_OSC | Gated oscillator enables |
| port_oe_o | output | N_PORT | Port output enables after reset override |
| port_do_o | output | N_PORT | Port output data after reset override |

## Verification
A software read and a new cause can fall in the same cycle, where the clear and the set compete for one flag. The bench first leaves bit 1 set from a low-voltage reset. It then raises the read strobe and a one-cycle watchdog overflow at the same edge. The next value must be 0x01: the old flag is cleared and the new flag is kept. The bench also overlaps power-on-clear with a held low-voltage request. It judges that the wipe happens first and the flag is recorded after it.

// File: rtl/rsthub_pkg.sv
package rsthub_pkg;
  localparam int CAUSE_W   = 8;
  localparam int CAUSE_WDT = 0;
  localparam int CAUSE_LVD = 1;

  typedef struct packed {
    logic por;
    logic lvd;
    logic wdt;
    logic ext;
  } rst_src_t;
endpackage

// File: rtl/pin_width_filter.sv
module pin_width_filter #(
  parameter int MIN_TICKS = 10
) (
  input  logic clk,
  input  logic srst,
  input  logic tick,
  input  logic supply_ok,
  input  logic pin_n,
  output logic hit
);
  localparam int CW = $clog2(MIN_TICKS + 1);
  localparam logic [CW-1:0] FULL = CW'(MIN_TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (srst || pin_n)
      cnt <= '0;
    else if (tick && supply_ok && cnt != FULL)
      cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == FULL);

  // R1
  pin_high_clears_chk: assert property (@(posedge clk) disable iff (srst)
    pin_n |=> !hit);
  // R2
  count_needs_supply_chk: assert property (@(posedge clk) disable iff (srst)
    $rose(hit) |-> $past(tick && supply_ok && !pin_n));
endmodule

// File: rtl/cause_flags.sv
module cause_flags
  import rsthub_pkg::*;
(
  input  logic               clk,
  input  logic               srst,
  input  logic               wdt_set,
  input  logic               lvd_set,
  input  logic               rd,
  output logic [CAUSE_W-1:0] flags
);
  logic [CAUSE_W-1:0] set_vec;

  always_comb begin
    set_vec = '0;
    set_vec[CAUSE_WDT] = wdt_set;
    set_vec[CAUSE_LVD] = lvd_set;
  end

  always_ff @(posedge clk) begin
    if (srst)
      flags <= '0;
    else
      flags <= (rd ? '0 : flags) | set_vec;
  end

  // R6
  por_wipes_chk: assert property (@(posedge clk)
    srst |=> (flags == '0));
  // R4
  wdt_flag_chk: assert property (@(posedge clk) disable iff (srst)
    wdt_set |=> flags[CAUSE_WDT]);
  // R5
  read_clears_chk: assert property (@(posedge clk) disable iff (srst)
    (rd && !wdt_set && !lvd_set) |=> (flags == '0));
endmodule

// File: rtl/release_stretch.sv
module release_stretch
  import rsthub_pkg::*;
#(
  parameter int RELEASE_CYC = 16
) (
  input  logic     clk,
  input  rst_src_t src,
  output logic     rst_o,
  output logic     lvd_dom_o,
  output logic     por_dom_o
);
  localparam int HW = $clog2(RELEASE_CYC + 1);
  localparam logic [HW-1:0] LAST = HW'(RELEASE_CYC - 1);

  logic          any_src;
  logic [HW-1:0] hold;

  assign any_src = src.por | src.lvd | src.wdt | src.ext;

  always_ff @(posedge clk) begin
    if (src.por) begin
      rst_o     <= 1'b1;
      lvd_dom_o <= 1'b1;
      por_dom_o <= 1'b1;
      hold      <= '0;
    end else if (any_src) begin
      rst_o <= 1'b1;
      hold  <= '0;
      if (src.wdt || src.ext)
        lvd_dom_o <= 1'b1;
    end else if (rst_o) begin
      if (hold == LAST) begin
        rst_o     <= 1'b0;
        lvd_dom_o <= 1'b0;
        por_dom_o <= 1'b0;
        hold      <= '0;
      end else begin
        hold <= hold + 1'b1;
      end
    end
  end

  // R3
  request_asserts_chk: assert property (@(posedge clk) disable iff (src.por)
    any_src |=> rst_o);
  // R3
  release_quiet_chk: assert property (@(posedge clk) disable iff (src.por)
    $fell(rst_o) |-> $past(!any_src));
  // R7
  lvd_spared_chk: assert property (@(posedge clk) disable iff (src.por)
    (src.lvd && !src.wdt && !src.ext && !rst_o) |=> !lvd_dom_o);
endmodule

// File: rtl/reset_hub.sv
module reset_hub
  import rsthub_pkg::*;
#(
  parameter int MIN_TICKS   = 10,
  parameter int RELEASE_CYC = 16,
  parameter int N_OSC       = 4,
  parameter int N_PORT      = 8,
  parameter int LOW_PIN     = 5
) (
  input  logic               clk,
  input  logic               por_i,
  input  logic               tick_i,
  input  logic               supply_ok_i,
  input  logic               ext_rst_n_i,
  input  logic               lvd_req_i,
  input  logic               wdt_ovf_i,
  input  logic               cause_rd_i,
  input  logic [N_OSC-1:0]   osc_req_i,
  input  logic [N_PORT-1:0]  port_oe_i,
  input  logic [N_PORT-1:0]  port_do_i,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               sys_rst_o,
  output logic               wdt_rst_o,
  output logic               lvd_rst_o,
  output logic               ram_keep_o,
  output logic [N_OSC-1:0]   osc_en_o,
  output logic [N_PORT-1:0]  port_oe_o,
  output logic [N_PORT-1:0]  port_do_o
);
  logic     ext_hit;
  logic     rst_q;
  logic     lvd_dom;
  logic     por_dom;
  rst_src_t src;

  pin_width_filter #(.MIN_TICKS(MIN_TICKS)) u_filter (
    .clk       (clk),
    .srst      (por_i),
    .tick      (tick_i),
    .supply_ok (supply_ok_i),
    .pin_n     (ext_rst_n_i),
    .hit       (ext_hit)
  );

  assign src.por = por_i;
  assign src.lvd = lvd_req_i;
  assign src.wdt = wdt_ovf_i;
  assign src.ext = ext_hit;

  release_stretch #(.RELEASE_CYC(RELEASE_CYC)) u_stretch (
    .clk       (clk),
    .src       (src),
    .rst_o     (rst_q),
    .lvd_dom_o (lvd_dom),
    .por_dom_o (por_dom)
  );

  cause_flags u_cause (
    .clk     (clk),
    .srst    (por_i),
    .wdt_set (wdt_ovf_i),
    .lvd_set (lvd_req_i),
    .rd      (cause_rd_i),
    .flags   (cause_o)
  );

  assign sys_rst_o  = rst_q;
  assign wdt_rst_o  = rst_q;
  assign lvd_rst_o  = lvd_dom;
  assign ram_keep_o = ~por_dom;
  assign osc_en_o   = rst_q ? '0 : osc_req_i;

  for (genvar i = 0; i < N_PORT; i++) begin : g_port
    if (i == LOW_PIN) begin : g_low
      assign port_oe_o[i] = rst_q ? 1'b1 : port_oe_i[i];
      assign port_do_o[i] = rst_q ? 1'b0 : port_do_i[i];
    end else begin : g_hiz
      assign port_oe_o[i] = rst_q ? 1'b0 : port_oe_i[i];
      assign port_do_o[i] = port_do_i[i];
    end
  end

  // R11
  por_drops_keep_chk: assert property (@(posedge clk)
    por_i |=> !ram_keep_o);
  // R8
  wdt_dom_chk: assert property (@(posedge clk) disable iff (por_i)
    wdt_ovf_i |=> wdt_rst_o);
endmodule

// File: tb/reset_hub_test.sv
module reset_hub_test;
  logic       clk = 1'b0;
  logic       por_i = 1'b1;
  logic       tick_i = 1'b0;
  logic       supply_ok_i = 1'b1;
  logic       ext_rst_n_i = 1'b1;
  logic       lvd_req_i = 1'b0;
  logic       wdt_ovf_i = 1'b0;
  logic       cause_rd_i = 1'b0;
  logic [3:0] osc_req_i = 4'hF;
  logic [7:0] port_oe_i = 8'hF0;
  logic [7:0] port_do_i = 8'hFF;
  logic [7:0] cause_o;
  logic       sys_rst_o, wdt_rst_o, lvd_rst_o, ram_keep_o;
  logic [3:0] osc_en_o;
  logic [7:0] port_oe_o, port_do_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  reset_hub uut (
    .clk(clk), .por_i(por_i), .tick_i(tick_i), .supply_ok_i(supply_ok_i),
    .ext_rst_n_i(ext_rst_n_i), .lvd_req_i(lvd_req_i), .wdt_ovf_i(wdt_ovf_i),
    .cause_rd_i(cause_rd_i), .osc_req_i(osc_req_i), .port_oe_i(port_oe_i),
    .port_do_i(port_do_i), .cause_o(cause_o), .sys_rst_o(sys_rst_o),
    .wdt_rst_o(wdt_rst_o), .lvd_rst_o(lvd_rst_o), .ram_keep_o(ram_keep_o),
    .osc_en_o(osc_en_o), .port_oe_o(port_oe_o), .port_do_o(port_do_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic give_ticks(int n);
    repeat (n) begin
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
    end
  endtask

  // counts edges from the drive point until sys_rst_o is low
  task automatic wait_release(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sys_rst_o && n < 200);
  endtask

  task automatic t_reset_state();
    int n;
    repeat (4) @(negedge clk);
    chk("R3 rst during por", sys_rst_o, 1);
    chk("R6 cause after por", cause_o, 8'h00);
    chk("R11 keep during por", ram_keep_o, 0);
    chk("R9 osc off", osc_en_o, 4'h0);
    chk("R10 port oe", port_oe_o, 8'h20);
    chk("R10 port do", port_do_o, 8'hDF);
    chk("R8 wdt dom", wdt_rst_o, 1);
    chk("R7 lvd dom on por", lvd_rst_o, 1);
    por_i = 1'b0;
    wait_release(n);
    chk("R3 release delay", n, 16);
    chk("R11 keep after", ram_keep_o, 1);
    chk("R9 osc follows", osc_en_o, 4'hF);
    chk("R10 oe follows", port_oe_o, 8'hF0);
    chk("R10 do follows", port_do_o, 8'hFF);
  endtask

  task automatic t_pin_width();
    int n;
    @(negedge clk) ext_rst_n_i = 1'b0;
    give_ticks(9);
    repeat (3) @(negedge clk);
    chk("R1 nine ticks no reset", sys_rst_o, 0);
    give_ticks(1);
    @(negedge clk);
    chk("R1 tenth tick resets", sys_rst_o, 1);
    chk("R7 ext resets lvd dom", lvd_rst_o, 1);
    chk("R11 keep on ext", ram_keep_o, 1);
    ext_rst_n_i = 1'b1;
    wait_release(n);
    chk("R4 ext sets no flag", cause_o, 8'h00);
    // interrupted pulse restarts the count
    @(negedge clk) ext_rst_n_i = 1'b0;
    give_ticks(6);
    @(negedge clk) ext_rst_n_i = 1'b1;
    @(negedge clk) ext_rst_n_i = 1'b0;
    give_ticks(6);
    repeat (3) @(negedge clk);
    chk("R1 high clears count", sys_rst_o, 0);
    @(negedge clk) ext_rst_n_i = 1'b1;
  endtask

  task automatic t_supply();
    int n;
    @(negedge clk) ext_rst_n_i = 1'b0;
    give_ticks(6);
    supply_ok_i = 1'b0;
    give_ticks(8);
    supply_ok_i = 1'b1;
    give_ticks(3);
    repeat (3) @(negedge clk);
    chk("R2 invalid ticks skipped", sys_rst_o, 0);
    give_ticks(1);
    @(negedge clk);
    chk("R2 count kept", sys_rst_o, 1);
    ext_rst_n_i = 1'b1;
    wait_release(n);
  endtask

  task automatic t_watchdog();
    int n;
    @(negedge clk) wdt_ovf_i = 1'b1;
    @(negedge clk) wdt_ovf_i = 1'b0;
    chk("R3 wdt asserts", sys_rst_o, 1);
    chk("R8 wdt dom on wdt", wdt_rst_o, 1);
    chk("R7 wdt resets lvd dom", lvd_rst_o, 1);
    chk("R4 wdt bit0", cause_o, 8'h01);
    wait_release(n);
    chk("R3 wdt release", n, 16);
    @(negedge clk) cause_rd_i = 1'b1;
    @(negedge clk) cause_rd_i = 1'b0;
    chk("R5 read clears", cause_o, 8'h00);
  endtask

  task automatic t_lvd_and_clash();
    int n;
    bit lvd_dom_seen = 1'b0;
    @(negedge clk) lvd_req_i = 1'b1;
    repeat (3) begin
      @(negedge clk);
      if (lvd_rst_o) lvd_dom_seen = 1'b1;
    end
    chk("R3 lvd asserts", sys_rst_o, 1);
    lvd_req_i = 1'b0;
    wait_release(n);
    chk("R7 lvd dom spared", lvd_dom_seen, 0);
    chk("R4 lvd bit1", cause_o, 8'h02);
    @(negedge clk) begin cause_rd_i = 1'b1; wdt_ovf_i = 1'b1; end
    @(negedge clk) begin cause_rd_i = 1'b0; wdt_ovf_i = 1'b0; end
    chk("R5 set beats clear", cause_o, 8'h01);
    wait_release(n);
  endtask

  task automatic t_por_wipe();
    int n;
    chk("R5 flag held", cause_o, 8'h01);
    @(negedge clk) begin por_i = 1'b1; lvd_req_i = 1'b1; end
    @(negedge clk);
    chk("R6 por wipes", cause_o, 8'h00);
    chk("R11 keep low", ram_keep_o, 0);
    @(negedge clk) por_i = 1'b0;
    repeat (2) @(negedge clk);
    lvd_req_i = 1'b0;
    wait_release(n);
    chk("R6 lvd flag after power-up", cause_o, 8'h02);
    chk("R11 keep back", ram_keep_o, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_pin_width();
    t_supply();
    t_watchdog();
    t_lvd_and_clash();
    t_por_wipe();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule